// File: doc/BRIEF.md
# Endpoint Bank Byte Counter

This block keeps the byte count of one device endpoint that works on two packet banks in turn, and it raises a flag when an OUT packet is shorter than the endpoint's maximum packet size. Software fills an IN bank one byte per write pulse and hands it over with a commit pulse. It drains an OUT bank one byte per read pulse and gives it back with a release pulse. The link side reports the length of each OUT packet it receives, and the bank it went to. It also reports when an IN bank has gone out on the wire.

The visible count always belongs to the bank in use. A commit or a release moves the bank pointer to the other bank and reloads the count from that bank. The short flag is computed again only at those moments. An endpoint reset pulse clears every piece of state. A disable pulse clears only the short flag.

Top module: `ep_bank_counter`

## Requirements
- R1: A `cpu_wr` pulse adds one to `byte_cnt`. A `cpu_rd` pulse without `cpu_wr` subtracts one. The result appears one clock after the pulse.
- R2: The maximum packet size is 8 shifted left by `cfg_size` (code 0 gives 8 and code 7 gives 1024). A write is ignored when the count is not below that size. A read is ignored when the count is zero. The count never wraps.
- R3: A `cpu_commit` pulse does four things. It stores the count into the current bank, marks that bank full, toggles `cur_bank` and reloads the count from the other bank.
- R4: A `cpu_release` pulse (without commit) marks the current bank empty, toggles `cur_bank` and reloads the count from the other bank.
- R5: A valid `usb_rx_len` stores the length in bank `usb_rx_bank` and marks that bank full. If that bank is the current one, is empty, and no commit or release occurs in the same cycle, the visible count is loaded with the length.
- R6: On a reload, both outputs come from the other bank. If that bank is full, the count becomes its stored count and the flag is set when that count is below the maximum size. If that bank is empty, the count and the flag both become zero.
- R7: `short_pkt` changes only in cycles with a reload, a load from the link side, an endpoint reset or a disable. Plain writes and reads leave it alone.
- R8: An `ep_reset` pulse clears the count, the short flag, both bank-full flags and the bank pointer.
- R9: An `ep_disable` pulse clears `short_pkt` and leaves the count, the pointer and the bank flags unchanged.
- R10: A `usb_tx_done` pulse clears the full flag of bank `usb_tx_bank`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_size | input | 3 | Maximum packet size code, size = 8 << code |
| ep_reset | input | 1 | Endpoint reset pulse |
| ep_disable | input | 1 | Endpoint disable pulse |
| cpu_wr | input | 1 | One byte written for IN |
| cpu_rd | input | 1 | One byte read for OUT |
| cpu_commit | input | 1 | Current IN bank handed to the link |
| cpu_release | input | 1 | Current OUT bank handed back |
| usb_rx_valid | input | 1 | OUT packet received |
| usb_rx_bank | input | 1 | Bank that received the packet |
| usb_rx_len | input | 11 | Received packet length |
| usb_tx_done | input | 1 | IN bank sent |
| usb_tx_bank | input | 1 | Bank that was sent |
| byte_cnt | output | 11 | Byte count of the bank in use |
| short_pkt | output | 1 | Short packet flag |
| cur_bank | output | 1 | Bank in use |
| bank_full | output | 2 | Full flag per bank |

## Verification
The bench pushes writes past the maximum size and reads past zero. A design that wraps there would show a count near the top of the range or a count of zero. It commits and releases with the other bank both full and empty. A design that reloads from the wrong bank, or keeps a stale count, would show the previous count or a nonzero value after an empty reload. It delivers a packet into the bank not in use and then issues a disable. A design that recomputes the flag too eagerly, or whose disable touches the count, would change `short_pkt` or `byte_cnt` where both should hold.

// File: rtl/ep_bank_counter.sv
module ep_bank_counter #(
  parameter int CNT_W = 11,
  parameter int CFG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_size,
  input  logic             ep_reset,
  input  logic             ep_disable,
  input  logic             cpu_wr,
  input  logic             cpu_rd,
  input  logic             cpu_commit,
  input  logic             cpu_release,
  input  logic             usb_rx_valid,
  input  logic             usb_rx_bank,
  input  logic [CNT_W-1:0] usb_rx_len,
  input  logic             usb_tx_done,
  input  logic             usb_tx_bank,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             short_pkt,
  output logic             cur_bank,
  output logic [1:0]       bank_full
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] BASE = CNT_W'(8);

  logic [CNT_W-1:0] cnt_q;
  logic             short_q;
  logic             cur_q;
  logic [1:0]       full_q;
  logic [CNT_W-1:0] bank_cnt [2];

  logic [CNT_W-1:0] max_size;
  logic             nxt;
  logic             ctl;
  logic [CNT_W-1:0] rl_cnt;
  logic             rl_short;
  logic             rx_cur_load;
  logic             wr_ok;
  logic             rd_ok;

  assign max_size    = BASE << cfg_size;
  assign nxt         = ~cur_q;
  assign ctl         = cpu_commit | cpu_release;
  assign rl_cnt      = full_q[nxt] ? bank_cnt[nxt] : '0;
  assign rl_short    = full_q[nxt] && (bank_cnt[nxt] < max_size);
  assign rx_cur_load = usb_rx_valid && (usb_rx_bank == cur_q) && !full_q[cur_q];
  assign wr_ok       = cpu_wr && (cnt_q < max_size);
  assign rd_ok       = cpu_rd && !cpu_wr && (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      short_q <= 1'b0;
      cur_q   <= 1'b0;
      full_q  <= '0;
      for (int b = 0; b < 2; b++) bank_cnt[b] <= '0;
    end else if (ep_reset) begin
      cnt_q   <= '0;
      short_q <= 1'b0;
      cur_q   <= 1'b0;
      full_q  <= '0;
      for (int b = 0; b < 2; b++) bank_cnt[b] <= '0;
    end else begin
      if (usb_tx_done) full_q[usb_tx_bank] <= 1'b0;
      if (usb_rx_valid) begin
        bank_cnt[usb_rx_bank] <= usb_rx_len;
        full_q[usb_rx_bank]   <= 1'b1;
      end
      if (ctl) begin
        if (cpu_commit) begin
          bank_cnt[cur_q] <= cnt_q;
          full_q[cur_q]   <= 1'b1;
        end else begin
          full_q[cur_q]   <= 1'b0;
        end
        cur_q   <= nxt;
        cnt_q   <= rl_cnt;
        short_q <= rl_short;
      end else if (rx_cur_load) begin
        cnt_q   <= usb_rx_len;
        short_q <= usb_rx_len < max_size;
      end else if (wr_ok) begin
        cnt_q <= cnt_q + ONE;
      end else if (rd_ok) begin
        cnt_q <= cnt_q - ONE;
      end
      if (ep_disable) short_q <= 1'b0;
    end
  end

  assign byte_cnt  = cnt_q;
  assign short_pkt = short_q;
  assign cur_bank  = cur_q;
  assign bank_full = full_q;

  logic quiet;
  assign quiet = !ep_reset && !ctl && !usb_rx_valid;

  AST_WR_INC: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && cpu_wr && (byte_cnt < max_size) |=> byte_cnt == $past(byte_cnt) + ONE); // R1
  AST_RD_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && cpu_rd && !cpu_wr && (byte_cnt != '0) |=> byte_cnt == $past(byte_cnt) - ONE); // R1
  AST_RD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && cpu_rd && !cpu_wr && (byte_cnt == '0) |=> byte_cnt == '0); // R2
  AST_BANK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_reset && ctl |=> cur_bank != $past(cur_bank)); // R3
  AST_SHORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && !ep_disable |=> $stable(short_pkt)); // R7
  AST_EP_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    ep_reset |=> byte_cnt == '0 && !short_pkt && bank_full == 2'b00 && !cur_bank); // R8
  AST_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ep_disable && !ep_reset |=> !short_pkt); // R9

endmodule

// File: tb/test_ep_bank_counter.sv
`timescale 1ns/100ps
module test_ep_bank_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_size = 3'd0;
  logic        ep_reset = 1'b0, ep_disable = 1'b0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_commit = 1'b0, cpu_release = 1'b0;
  logic        usb_rx_valid = 1'b0, usb_rx_bank = 1'b0;
  logic [10:0] usb_rx_len = '0;
  logic        usb_tx_done = 1'b0, usb_tx_bank = 1'b0;
  logic [10:0] byte_cnt;
  logic        short_pkt, cur_bank;
  logic [1:0]  bank_full;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ep_bank_counter i_ep_bank_counter (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size),
    .ep_reset(ep_reset), .ep_disable(ep_disable),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_commit(cpu_commit), .cpu_release(cpu_release),
    .usb_rx_valid(usb_rx_valid), .usb_rx_bank(usb_rx_bank), .usb_rx_len(usb_rx_len),
    .usb_tx_done(usb_tx_done), .usb_tx_bank(usb_tx_bank),
    .byte_cnt(byte_cnt), .short_pkt(short_pkt), .cur_bank(cur_bank), .bank_full(bank_full)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic state(input string req, input int cnt, input int sh, input int cur, input int full);
    check(req, "byte_cnt", byte_cnt, cnt);
    check(req, "short_pkt", short_pkt, sh);
    check(req, "cur_bank", cur_bank, cur);
    check(req, "bank_full", bank_full, full);
  endtask

  task automatic writes(input int n);
    @(negedge clk) cpu_wr = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk) cpu_wr = 1'b0;
  endtask

  task automatic reads(input int n);
    @(negedge clk) cpu_rd = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk) cpu_rd = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk) cpu_commit = 1'b1;
    @(negedge clk) cpu_commit = 1'b0;
  endtask

  task automatic release_bank();
    @(negedge clk) cpu_release = 1'b1;
    @(negedge clk) cpu_release = 1'b0;
  endtask

  task automatic rx(input bit bank, input int len);
    @(negedge clk) begin usb_rx_valid = 1'b1; usb_rx_bank = bank; usb_rx_len = 11'(len); end
    @(negedge clk) usb_rx_valid = 1'b0;
  endtask

  task automatic pulse_reset();
    @(negedge clk) ep_reset = 1'b1;
    @(negedge clk) ep_reset = 1'b0;
  endtask

  task automatic pulse_disable();
    @(negedge clk) ep_disable = 1'b1;
    @(negedge clk) ep_disable = 1'b0;
  endtask

  task automatic t_reset_state();
    state("R8 reset", 0, 0, 0, 0);
  endtask

  task automatic t_in_path();
    cfg_size = 3'd0;
    writes(5);
    check("R1", "count after 5 writes", byte_cnt, 5);
    writes(5);
    check("R2", "count capped at 8", byte_cnt, 8);
    commit();
    state("R3 commit to empty bank (R6)", 0, 0, 1, 1);
    writes(3);
    check("R1", "count in bank 1", byte_cnt, 3);
    commit();
    state("R3 commit to full bank (R6 not short)", 8, 0, 0, 3);
    @(negedge clk) begin usb_tx_done = 1'b1; usb_tx_bank = 1'b0; end
    @(negedge clk) usb_tx_done = 1'b0;
    check("R10", "bank_full after tx bank0", bank_full, 2);
    commit();
    state("R6 reload short count", 3, 1, 1, 3);
    pulse_reset();
    state("R8 reset mid traffic", 0, 0, 0, 0);
    cfg_size = 3'd1;
    writes(20);
    check("R2", "count capped at 16", byte_cnt, 16);
    pulse_reset();
  endtask

  task automatic t_out_path();
    cfg_size = 3'd3;
    rx(1'b0, 20);
    state("R5 load into current empty bank", 20, 1, 0, 1);
    rx(1'b1, 64);
    state("R5 rx into other bank keeps count", 20, 1, 0, 3);
    reads(3);
    check("R1", "count after 3 reads", byte_cnt, 17);
    release_bank();
    state("R4 release to full bank", 64, 0, 1, 2);
    rx(1'b0, 5);
    state("R7 short held on rx to other bank", 64, 0, 1, 3);
    release_bank();
    state("R4 release reload short", 5, 1, 0, 1);
    pulse_disable();
    state("R9 disable clears only flag", 5, 0, 0, 1);
    reads(7);
    check("R2", "count floored at 0", byte_cnt, 0);
    release_bank();
    state("R6 release to empty bank", 0, 0, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_in_path();
    t_out_path();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule